// File: doc/BRIEF.md
# Fixed-Head Disk Controller Programmed-I/O Decoder

This block sits between the processor's I/O bus and a fixed-head disk controller on a 12-bit machine. It watches the I/O transfer strobe, the 6-bit device code and the three low instruction bits. It acts on three device codes for the disk and one for extended addressing.

Each command is split into separate actions. The processor fires three timing pulses in turn: IOP1, IOP2 and IOP4. Each action of a command belongs to one of these pulses. The block does three kinds of work:

- It holds the 12-bit disk memory address, the extended address, three interrupt enables, and sticky flags for parity error, data late and completion.
- It answers the processor with a skip request, a clear-AC request and a word to load into AC.
- It issues one-cycle start-read and start-write strobes to the transfer engine.

The disk mechanics drive the flags through set inputs and level inputs. The interrupt request is formed from these flags and the enables.

Top module: `disk_iot_decoder`

## Requirements
- R1: After reset the disk memory address, extended address, interrupt enables and the parity, data-late and completion flags are all zero, and no request output is active.
- R2: Command 6601 clears, at IOP1, the disk memory address and the parity, data-late and completion flags. The interrupt enables and the extended address keep their values.
- R3: Command 6603 performs the 6601 clear at IOP1. At IOP2 it loads the disk memory address from AC and requests AC clear. In the cycle after the IOP2 cycle, start_read is high for exactly one cycle.
- R4: Command 6605 performs the 6601 clear at IOP1. At IOP4 it loads the disk memory address from AC and requests AC clear. In the cycle after the IOP4 cycle, start_write is high for exactly one cycle. It never raises start_read.
- R5: Command 6612 requests a skip at IOP2 exactly when the disk memory address equals disk_word_addr. It requests AC clear at IOP2 in either case.
- R6: Commands 6611 and 6615 clear the three interrupt enables and the extended address at IOP1. At IOP4, 6615 then loads the enables from AC bits of weight 0400 (error), 0200 (photocell) and 0100 (done). It loads the low three extended-address bits from AC weight 0070, with the upper bits zero, and requests AC clear.
- R7: Command 6616 loads AC at IOP4 with the status word. Its weights are:
  - 4000 photocell
  - 2000 data request enable
  - 1000 write lock
  - 0400, 0200, 0100 the error, photocell and done enables
  - 0070 the low three extended-address bits
  - 0004 data late
  - 0002 no disk
  - 0001 parity
- R8: At IOP2, 6621 skips if any error is present (data late, parity, write lock or no disk). 6622 skips if the completion flag is set. 6623 skips if either holds. No skip is requested at IOP1 or IOP4.
- R9: Command 6626 requests AC clear at IOP2 and loads the disk memory address into AC at IOP4.
- R10: Command 6641 clears the extended address at IOP1. Command 6643 clears it at IOP1, loads it from the low eight AC bits at IOP2 and requests AC clear there. Command 6645 requests AC clear at IOP2 and loads the zero-extended extended address into AC at IOP4.
- R11: irq is high exactly when either of these holds: the error enable and any error are both set, or the done enable and the completion flag are both set.
- R12: With iot low, or with an unanswered device code, no skip, AC clear, AC load or start strobe occurs, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot | input | 1 | I/O transfer instruction in progress |
| dev_sel | input | 6 | Device code field of the instruction |
| op_low | input | 3 | Low three instruction bits |
| iop1 | input | 1 | First timing pulse |
| iop2 | input | 1 | Second timing pulse |
| iop4 | input | 1 | Third timing pulse |
| acc | input | 12 | Accumulator value |
| disk_word_addr | input | 12 | Word address currently under the heads |
| photocell | input | 1 | Photocell level |
| data_req_en | input | 1 | Data request enable level |
| write_lock | input | 1 | Write lock level (error) |
| no_disk | input | 1 | Nonexistent disk level (error) |
| parity_set | input | 1 | Sets the parity error flag |
| late_set | input | 1 | Sets the data-late flag |
| done_set | input | 1 | Sets the completion flag |
| skip_req | output | 1 | Skip request |
| clear_ac_req | output | 1 | Clear AC request |
| load_ac_req | output | 1 | Load AC from load_ac_data |
| load_ac_data | output | 12 | Word for AC |
| start_read | output | 1 | One-cycle read start strobe |
| start_write | output | 1 | One-cycle write start strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default extended-address width of eight bits. This makes every weight of the status word visible through 6616, including the three extended-address bits it reports. It also lets 6643 and 6645 round-trip a full byte, so that 6615 can be seen to zero the upper five bits. Each command is run through all three pulses with a dead cycle between them. This shows that every action lands only in its own pulse and that the start strobes follow the right one.

// File: rtl/disk_iot_decoder.sv
module disk_iot_decoder #(
  parameter int EXT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iot,
  input  logic [5:0]  dev_sel,
  input  logic [2:0]  op_low,
  input  logic        iop1,
  input  logic        iop2,
  input  logic        iop4,
  input  logic [11:0] acc,
  input  logic [11:0] disk_word_addr,
  input  logic        photocell,
  input  logic        data_req_en,
  input  logic        write_lock,
  input  logic        no_disk,
  input  logic        parity_set,
  input  logic        late_set,
  input  logic        done_set,
  output logic        skip_req,
  output logic        clear_ac_req,
  output logic        load_ac_req,
  output logic [11:0] load_ac_data,
  output logic        start_read,
  output logic        start_write,
  output logic        irq
);
  localparam int PAD_W = 12 - EXT_W;

  logic [11:0]      dma_q;
  logic [EXT_W-1:0] ext_q;
  logic             eie_q, pie_q, cie_q;
  logic             per_q, late_q, done_q;

  logic g60, g61, g62, g64;
  assign g60 = iot && dev_sel == 6'o60;
  assign g61 = iot && dev_sel == 6'o61;
  assign g62 = iot && dev_sel == 6'o62;
  assign g64 = iot && dev_sel == 6'o64;

  logic c01, c03, c05, c11, c12, c15, c16, c21, c22, c23, c26, c41, c43, c45;
  assign c01 = g60 && op_low == 3'd1;
  assign c03 = g60 && op_low == 3'd3;
  assign c05 = g60 && op_low == 3'd5;
  assign c11 = g61 && op_low == 3'd1;
  assign c12 = g61 && op_low == 3'd2;
  assign c15 = g61 && op_low == 3'd5;
  assign c16 = g61 && op_low == 3'd6;
  assign c21 = g62 && op_low == 3'd1;
  assign c22 = g62 && op_low == 3'd2;
  assign c23 = g62 && op_low == 3'd3;
  assign c26 = g62 && op_low == 3'd6;
  assign c41 = g64 && op_low == 3'd1;
  assign c43 = g64 && op_low == 3'd3;
  assign c45 = g64 && op_low == 3'd5;

  logic sys_clr, ld_dma, ie_clr, ie_ld, ext_clr, ext_ld, any_err;
  assign sys_clr = iop1 && (c01 || c03 || c05);
  assign ld_dma  = (iop2 && c03) || (iop4 && c05);
  assign ie_clr  = iop1 && (c11 || c15);
  assign ie_ld   = iop4 && c15;
  assign ext_clr = ie_clr || (iop1 && (c41 || c43));
  assign ext_ld  = iop2 && c43;
  assign any_err = late_q || per_q || write_lock || no_disk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q       <= '0;
      ext_q       <= '0;
      {eie_q, pie_q, cie_q} <= '0;
      per_q       <= 1'b0;
      late_q      <= 1'b0;
      done_q      <= 1'b0;
      start_read  <= 1'b0;
      start_write <= 1'b0;
    end else begin
      if (ld_dma)       dma_q <= acc;
      else if (sys_clr) dma_q <= '0;
      per_q  <= parity_set || (per_q  && !sys_clr);
      late_q <= late_set   || (late_q && !sys_clr);
      done_q <= done_set   || (done_q && !sys_clr);
      if (ie_clr)     {eie_q, pie_q, cie_q} <= '0;
      else if (ie_ld) {eie_q, pie_q, cie_q} <= acc[8:6];
      if (ext_clr)     ext_q <= '0;
      else if (ie_ld)  ext_q <= {{(EXT_W-3){1'b0}}, acc[5:3]};
      else if (ext_ld) ext_q <= acc[EXT_W-1:0];
      start_read  <= iop2 && c03;
      start_write <= iop4 && c05;
    end
  end

  logic [11:0] status_w;
  assign status_w = {photocell, data_req_en, write_lock, eie_q, pie_q, cie_q,
                     ext_q[2:0], late_q, no_disk, per_q};

  assign skip_req = iop2 && ((c12 && dma_q == disk_word_addr) ||
                             (c21 && any_err) || (c22 && done_q) ||
                             (c23 && (any_err || done_q)));
  assign clear_ac_req = (iop2 && (c03 || c12 || c26 || c43 || c45)) ||
                        (iop4 && (c05 || c15));
  assign load_ac_req  = iop4 && (c16 || c26 || c45);
  assign load_ac_data = c16 ? status_w :
                        c26 ? dma_q : {{PAD_W{1'b0}}, ext_q};
  assign irq = (eie_q && any_err) || (cie_q && done_q);
endmodule

// File: rtl/disk_iot_decoder_chk.sv
module disk_iot_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iot,
  input logic [5:0]  dev_sel,
  input logic [2:0]  op_low,
  input logic        iop1,
  input logic        iop2,
  input logic        iop4,
  input logic [11:0] acc,
  input logic [11:0] dma_q,
  input logic        skip_req,
  input logic        clear_ac_req,
  input logic        load_ac_req,
  input logic        start_read,
  input logic        start_write
);
  logic rd_cmd, wr_cmd;
  assign rd_cmd = iot && dev_sel == 6'o60 && op_low == 3'd3;
  assign wr_cmd = iot && dev_sel == 6'o60 && op_low == 3'd5;

  assert_rd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iop2 && rd_cmd) |=> (dma_q == $past(acc) && start_read));
  assert_rd_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_read |-> $past(iop2 && rd_cmd));
  assert_wr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iop4 && wr_cmd) |=> (dma_q == $past(acc) && start_write && !start_read));
  assert_wr_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_write |-> $past(iop4 && wr_cmd));
  assert_skip_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (iop2 && iot));
  assert_load_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ac_req |-> (iop4 && iot));
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !iot |-> !(skip_req || clear_ac_req || load_ac_req));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !iot |=> $stable(dma_q));
endmodule

bind disk_iot_decoder disk_iot_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .iot(iot), .dev_sel(dev_sel), .op_low(op_low),
  .iop1(iop1), .iop2(iop2), .iop4(iop4), .acc(acc), .dma_q(dma_q),
  .skip_req(skip_req), .clear_ac_req(clear_ac_req), .load_ac_req(load_ac_req),
  .start_read(start_read), .start_write(start_write)
);

// File: tb/disk_iot_decoder_tb_top.sv
module disk_iot_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, iot = 1'b0;
  logic [5:0] dev_sel = '0;
  logic [2:0] op_low = '0;
  logic iop1 = 0, iop2 = 0, iop4 = 0;
  logic [11:0] acc = '0, disk_word_addr = '0;
  logic photocell = 0, data_req_en = 0, write_lock = 0, no_disk = 0;
  logic parity_set = 0, late_set = 0, done_set = 0;
  logic skip_req, clear_ac_req, load_ac_req, start_read, start_write, irq;
  logic [11:0] load_ac_data;

  always #2 clk = ~clk;

  disk_iot_decoder dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic cs[3], cc[3], cl[3], crd[3], cwr[3];
  logic [11:0] cd[3];

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [5:0] d, input logic [2:0] o, input logic [11:0] a,
                        input logic en = 1'b1);
    @(negedge clk);
    iot = en; dev_sel = d; op_low = o; acc = a;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      iop1 = (k == 0); iop2 = (k == 1); iop4 = (k == 2);
      #1;
      cs[k] = skip_req; cc[k] = clear_ac_req; cl[k] = load_ac_req; cd[k] = load_ac_data;
      @(negedge clk);
      iop1 = 0; iop2 = 0; iop4 = 0;
      #1;
      crd[k] = start_read; cwr[k] = start_write;
    end
    iot = 0;
  endtask

  task automatic pulse_flag(input int which);
    @(negedge clk);
    parity_set = (which == 0); late_set = (which == 1); done_set = (which == 2);
    @(negedge clk);
    parity_set = 0; late_set = 0; done_set = 0;
    #1;
  endtask

  function automatic logic [11:0] rd_status(); return cd[2]; endfunction

  task automatic t_reset();
    chk("R1 irq", {11'd0, irq}, 12'd0);
    chk("R1 strobes", {10'd0, start_read, start_write}, 12'd0);
    do_cmd(6'o61, 3'd6, 12'o7777);
    chk("R1 status", rd_status(), 12'o0000);
    do_cmd(6'o62, 3'd6, 12'o0);
    chk("R1 dma", cd[2], 12'o0000);
    do_cmd(6'o64, 3'd5, 12'o0);
    chk("R1 ext", cd[2], 12'o0000);
  endtask

  task automatic t_read();
    do_cmd(6'o60, 3'd3, 12'o1234);
    chk("R3 clr at iop1/2/4", {9'd0, cc[0], cc[1], cc[2]}, 12'b010);
    chk("R3 start_read after iop1/2/4", {9'd0, crd[0], crd[1], crd[2]}, 12'b010);
    chk("R3 no write", {9'd0, cwr[0], cwr[1], cwr[2]}, 12'b000);
    do_cmd(6'o62, 3'd6, 12'o0);
    chk("R3 dma loaded", cd[2], 12'o1234);
    chk("R9 clr/load pulses", {8'd0, cc[1], cc[2], cl[1], cl[2]}, 12'b1001);
  endtask

  task automatic t_write();
    do_cmd(6'o60, 3'd5, 12'o4321);
    chk("R4 clr at iop1/2/4", {9'd0, cc[0], cc[1], cc[2]}, 12'b001);
    chk("R4 start_write after iop1/2/4", {9'd0, cwr[0], cwr[1], cwr[2]}, 12'b001);
    chk("R4 no read", {9'd0, crd[0], crd[1], crd[2]}, 12'b000);
    do_cmd(6'o62, 3'd6, 12'o0);
    chk("R4 dma loaded", cd[2], 12'o4321);
  endtask

  task automatic t_ext();
    do_cmd(6'o64, 3'd3, 12'o7377);
    chk("R10 6643 clr at iop2", {9'd0, cc[0], cc[1], cc[2]}, 12'b010);
    do_cmd(6'o64, 3'd5, 12'o0);
    chk("R10 6645 readback", cd[2], 12'o0377);
    chk("R10 6645 clr/load", {8'd0, cc[1], cc[2], cl[1], cl[2]}, 12'b1001);
    do_cmd(6'o64, 3'd1, 12'o0);
    do_cmd(6'o64, 3'd5, 12'o0);
    chk("R10 6641 clears ext", cd[2], 12'o0000);
  endtask

  task automatic t_enables();
    do_cmd(6'o64, 3'd3, 12'o0377);
    do_cmd(6'o61, 3'd5, 12'o0750);
    chk("R6 6615 clr at iop4", {9'd0, cc[0], cc[1], cc[2]}, 12'b001);
    do_cmd(6'o61, 3'd6, 12'o0);
    chk("R6 enables+ext field", rd_status(), 12'o0750);
    chk("R7 load only at iop4", {9'd0, cl[0], cl[1], cl[2]}, 12'b001);
    do_cmd(6'o64, 3'd5, 12'o0);
    chk("R6 ext upper bits zero", cd[2], 12'o0005);
    do_cmd(6'o61, 3'd1, 12'o0);
    do_cmd(6'o61, 3'd6, 12'o0);
    chk("R6 6611 clears enables", rd_status(), 12'o0000);
  endtask

  task automatic t_sysclr();
    do_cmd(6'o60, 3'd3, 12'o0777);
    do_cmd(6'o61, 3'd5, 12'o0700);
    do_cmd(6'o64, 3'd3, 12'o0012);
    pulse_flag(0); pulse_flag(1); pulse_flag(2);
    do_cmd(6'o61, 3'd6, 12'o0);
    chk("R7 flags in status", rd_status(), 12'o0725);
    chk("R11 irq with errors", {11'd0, irq}, 12'd1);
    do_cmd(6'o60, 3'd1, 12'o0);
    do_cmd(6'o61, 3'd6, 12'o0);
    chk("R2 keeps enables/ext, clears flags", rd_status(), 12'o0720);
    do_cmd(6'o64, 3'd5, 12'o0);
    chk("R2 ext kept", cd[2], 12'o0012);
    do_cmd(6'o62, 3'd6, 12'o0);
    chk("R2 dma cleared", cd[2], 12'o0000);
    chk("R11 irq after clear", {11'd0, irq}, 12'd0);
  endtask

  task automatic t_skips();
    do_cmd(6'o60, 3'd1, 12'o0);
    do_cmd(6'o62, 3'd1, 12'o0); chk("R8 6621 no error", {11'd0, cs[1]}, 12'd0);
    do_cmd(6'o62, 3'd2, 12'o0); chk("R8 6622 no done", {11'd0, cs[1]}, 12'd0);
    do_cmd(6'o62, 3'd3, 12'o0); chk("R8 6623 neither", {11'd0, cs[1]}, 12'd0);
    pulse_flag(2);
    do_cmd(6'o62, 3'd2, 12'o0);
    chk("R8 6622 skip only at iop2", {9'd0, cs[0], cs[1], cs[2]}, 12'b010);
    do_cmd(6'o62, 3'd1, 12'o0); chk("R8 6621 done only", {11'd0, cs[1]}, 12'd0);
    do_cmd(6'o62, 3'd3, 12'o0); chk("R8 6623 done", {11'd0, cs[1]}, 12'd1);
    do_cmd(6'o60, 3'd1, 12'o0);
    write_lock = 1;
    do_cmd(6'o62, 3'd1, 12'o0); chk("R8 6621 write lock", {11'd0, cs[1]}, 12'd1);
    do_cmd(6'o62, 3'd3, 12'o0); chk("R8 6623 error", {11'd0, cs[1]}, 12'd1);
    write_lock = 0;
  endtask

  task automatic t_adc();
    do_cmd(6'o60, 3'd3, 12'o1357);
    disk_word_addr = 12'o1357;
    do_cmd(6'o61, 3'd2, 12'o0);
    chk("R5 match skip at iop2", {9'd0, cs[0], cs[1], cs[2]}, 12'b010);
    chk("R5 clr at iop2", {9'd0, cc[0], cc[1], cc[2]}, 12'b010);
    disk_word_addr = 12'o1356;
    do_cmd(6'o61, 3'd2, 12'o0);
    chk("R5 mismatch no skip", {11'd0, cs[1]}, 12'd0);
    chk("R5 mismatch still clr", {11'd0, cc[1]}, 12'd1);
  endtask

  task automatic t_irq();
    do_cmd(6'o60, 3'd1, 12'o0);
    do_cmd(6'o61, 3'd5, 12'o0100);
    chk("R11 idle", {11'd0, irq}, 12'd0);
    pulse_flag(2);
    chk("R11 done enable", {11'd0, irq}, 12'd1);
    do_cmd(6'o60, 3'd1, 12'o0);
    pulse_flag(0);
    chk("R11 parity masked", {11'd0, irq}, 12'd0);
    do_cmd(6'o61, 3'd5, 12'o0400);
    chk("R11 error enable", {11'd0, irq}, 12'd1);
    do_cmd(6'o60, 3'd1, 12'o0);
    no_disk = 1; #1;
    chk("R11 no-disk level", {11'd0, irq}, 12'd1);
    no_disk = 0;
  endtask

  task automatic t_status_levels();
    do_cmd(6'o61, 3'd1, 12'o0);
    photocell = 1; data_req_en = 1; write_lock = 1; no_disk = 1;
    do_cmd(6'o61, 3'd6, 12'o0);
    chk("R7 level weights", rd_status(), 12'o7002);
    photocell = 0; data_req_en = 0; write_lock = 0; no_disk = 0;
  endtask

  task automatic t_ignored();
    do_cmd(6'o60, 3'd3, 12'o2222);
    do_cmd(6'o60, 3'd3, 12'o5555, 1'b0);
    chk("R12 iot low no effects", {6'd0, cs[1], cc[1], cc[2], cl[2], crd[1], cwr[2]}, 12'd0);
    do_cmd(6'o63, 3'd6, 12'o0);
    chk("R12 other code no load", {10'd0, cl[2], cc[1]}, 12'd0);
    do_cmd(6'o62, 3'd6, 12'o0);
    chk("R12 dma untouched", cd[2], 12'o2222);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_read();
    t_write();
    t_ext();
    t_enables();
    t_sysclr();
    t_skips();
    t_adc();
    t_irq();
    t_status_levels();
    t_ignored();
    summary();
  end
endmodule